// File: doc/BRIEF.md
# Operand Address Generation Unit

This unit works out where the two operands of a two-operand instruction live. It is started with a mode and a register number for each operand, plus a byte/word size flag. It then produces, for each operand, either a flag saying the operand is a register (with the register number on the address output) or a 16-bit effective address in memory. It owns an eight-entry register file, in which register 6 is the stack pointer and register 7 is the instruction pointer. It applies the automatic pre-decrement and post-increment register updates itself. It fetches indexed-mode displacement words and indirection pointers through a simple request/ready read port.

The source operand is always resolved before the destination. Any register update caused by the source is written back before the destination is looked at, so both operands see a single, well-defined order of side effects. Word addresses with bit 0 set are quietly rounded down to even. The instruction pointer is the exception: when it is odd and an operand needs it, the unit raises an alignment trap and does not fetch through it. A decoder drives `start` and collects the results on `done`. The execution stage reaches the same registers through the register port.

Top module: `opnd_agu`

## Requirements
- R1: After reset, `busy`, `done`, `align_trap` and `mem_req` are 0 and all eight registers read 0.
- R2: Mode field encoding: bit 2 selects one level of indirection and bits 1..0 select the base mode: 0 register, 1 pre-decrement, 2 post-increment, 3 indexed. Mode 0 gives the is-register flag, with the register number zero-extended on the address output. Mode 4 uses the register contents as the address. Neither mode makes a memory access.
- R3: Pre-decrement lowers the register by the step and uses the new value. Post-increment uses the old value and then raises the register by the step. The step is 1 for byte operands and 2 for word operands, but always 2 for registers 6 and 7.
- R4: Indexed mode reads the word at the instruction pointer and adds 2 to the instruction pointer. The address is the register plus that word. For register 7, the advanced instruction pointer value is used.
- R5: Modes 5, 6 and 7 read a word at the computed address with bit 0 cleared, and the effective address is that word with bit 0 cleared.
- R6: The source is resolved first and its register update is written before the destination is resolved. Post-incrementing the same register for both operands gives two consecutive addresses.
- R7: Without indirection, a word operand's address has bit 0 cleared, and a byte operand's address keeps bit 0.
- R8: If an operand in any mode other than 0 needs the instruction pointer, either as its register or for an indexed displacement, and that pointer is odd, then `done` and `align_trap` pulse together. In that case there is no memory request and that operand changes no register.
- R9: `mem_req` stays high with a stable `mem_addr` until `mem_ready` is seen, and `mem_addr` bit 0 is always 0.
- R10: `done` is a one-cycle pulse due 3 clock edges after the edge that takes `start`, plus one edge for each memory read and one more for each cycle that read waits. `start` is ignored while `busy` is high.
- R11: The register port writes at a clock edge and reads combinationally. Writes are ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin resolving the operands presented this cycle |
| is_byte | input | 1 | Operands are bytes (1) or words (0) |
| src_mode | input | 3 | Source addressing mode |
| src_reg | input | 3 | Source register number |
| dst_mode | input | 3 | Destination addressing mode |
| dst_reg | input | 3 | Destination register number |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse: results valid |
| align_trap | output | 1 | Pulses with done when the instruction pointer was odd |
| src_is_reg | output | 1 | Source is a register |
| src_ea | output | 16 | Source effective address or register number |
| dst_is_reg | output | 1 | Destination is a register |
| dst_ea | output | 16 | Destination effective address or register number |
| mem_req | output | 1 | Word read request |
| mem_addr | output | 16 | Read address, always even |
| mem_ready | input | 1 | Read data is valid this cycle |
| mem_rdata | input | 16 | Read data |
| rf_we | input | 1 | Register port write enable |
| rf_waddr | input | 3 | Register port write index |
| rf_wdata | input | 16 | Register port write data |
| rf_raddr | input | 3 | Register port read index |
| rf_rdata | output | 16 | Register port read data |

## Verification
Every operation is timed from the edge that takes `start`. `done` is due at the third edge after it, plus one edge for each memory read and each cycle that read waits, or at the second edge when the source traps. The bench counts falling edges from that start edge until `done` and compares the count with the figure worked out from the modes and the programmed wait states. It reads the operand results and the register port at the falling edge where `done` is seen. A monitor checks each falling edge that a pending read keeps its address, and it counts completed reads so that modes which must not touch memory are shown to do so.

// File: rtl/agu_pkg.sv
// Shared types and constants for the operand address generation unit.
// Assumes an eight-entry register file with fixed stack and instruction pointers.
package agu_pkg;
    localparam int SP_IDX = 6;
    localparam int IP_IDX = 7;

    typedef enum logic [1:0] {
        AM_REG     = 2'd0,
        AM_PREDEC  = 2'd1,
        AM_POSTINC = 2'd2,
        AM_INDEX   = 2'd3
    } base_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EVAL = 2'd1,
        ST_IDX  = 2'd2,
        ST_IND  = 2'd3
    } agu_state_e;
endpackage

// File: rtl/agu_regfile.sv
// Register file: one update port from the sequencer, one external write port,
// three combinational read ports. Assumes the sequencer's update takes
// priority when both ports hit the same entry in one cycle.
module agu_regfile #(
    parameter int DW   = 16,
    parameter int NREG = 8,
    parameter int RW   = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          upd_we,
    input  logic [RW-1:0] upd_idx,
    input  logic [DW-1:0] upd_data,
    input  logic          ext_we,
    input  logic [RW-1:0] ext_idx,
    input  logic [DW-1:0] ext_data,
    input  logic [RW-1:0] ra_idx,
    output logic [DW-1:0] ra_data,
    input  logic [RW-1:0] rb_idx,
    output logic [DW-1:0] rb_data,
    input  logic [RW-1:0] rc_idx,
    output logic [DW-1:0] rc_data
);
    logic [DW-1:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_entry
        // Hold one register; sequencer update beats external write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[g] <= '0;
            else if (upd_we && upd_idx == RW'(g))
                regs[g] <= upd_data;
            else if (ext_we && ext_idx == RW'(g))
                regs[g] <= ext_data;
        end
    end

    // Combinational reads.
    assign ra_data = regs[ra_idx];
    assign rb_data = regs[rb_idx];
    assign rc_data = regs[rc_idx];

    // R11: an uncontested external write lands at the next edge.
    p_ext_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_we && !(upd_we && upd_idx == ext_idx)) |=> regs[$past(ext_idx)] == $past(ext_data));
endmodule

// File: rtl/agu_autostep.sv
// Computes the automatically stepped register value for pre-decrement and
// post-increment modes. Assumes the stack and instruction pointers (the top
// two entries) always move by a whole word.
module agu_autostep #(
    parameter int DW = 16,
    parameter int RW = 3
) (
    input  logic [DW-1:0] val,
    input  logic [RW-1:0] ridx,
    input  logic          byte_op,
    input  logic          down,
    output logic [DW-1:0] res
);
    import agu_pkg::*;

    logic [DW-1:0] step;

    // Pick the step size, then apply it in the requested direction.
    always_comb begin
        step = (byte_op && (int'(ridx) < SP_IDX)) ? DW'(1) : DW'(2);
        res  = down ? (val - step) : (val + step);
    end
endmodule

// File: rtl/opnd_agu.sv
// Operand address generation unit. Resolves the source operand, then the
// destination, applying register side effects in that order, fetching
// displacement and pointer words over a request/ready read port.
// Assumes mem_rdata is valid in the cycle mem_ready is high.
module opnd_agu #(
    parameter int DW   = 16,
    parameter int NREG = 8,
    parameter int RW   = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          is_byte,
    input  logic [2:0]    src_mode,
    input  logic [RW-1:0] src_reg,
    input  logic [2:0]    dst_mode,
    input  logic [RW-1:0] dst_reg,
    output logic          busy,
    output logic          done,
    output logic          align_trap,
    output logic          src_is_reg,
    output logic [DW-1:0] src_ea,
    output logic          dst_is_reg,
    output logic [DW-1:0] dst_ea,
    output logic          mem_req,
    output logic [DW-1:0] mem_addr,
    input  logic          mem_ready,
    input  logic [DW-1:0] mem_rdata,
    input  logic          rf_we,
    input  logic [RW-1:0] rf_waddr,
    input  logic [DW-1:0] rf_wdata,
    input  logic [RW-1:0] rf_raddr,
    output logic [DW-1:0] rf_rdata
);
    import agu_pkg::*;

    localparam logic [RW-1:0] IP_R = RW'(IP_IDX);

    agu_state_e    state;
    logic          phase_dst;
    logic          lat_byte;
    logic [2:0]    lat_smode, lat_dmode;
    logic [RW-1:0] lat_sreg, lat_dreg;
    logic [DW-1:0] ptr;

    logic [2:0]    cur_mode;
    logic [RW-1:0] cur_reg;
    base_mode_e    cur_base;
    logic          cur_ind;
    logic [DW-1:0] cur_val, ip_val, step_val, idx_addr;

    logic          upd_we;
    logic [RW-1:0] upd_idx;
    logic [DW-1:0] upd_data;

    logic          trap_now, fin, fin_is_reg, go_ind, go_idx;
    logic [DW-1:0] fin_ea, nxt_ptr;

    // Clear bit 0 for word operands only.
    function automatic logic [DW-1:0] align_ea(input logic [DW-1:0] a, input logic byt);
        return byt ? a : {a[DW-1:1], 1'b0};
    endfunction

    // Select the operand currently being resolved.
    always_comb begin
        cur_mode = phase_dst ? lat_dmode : lat_smode;
        cur_reg  = phase_dst ? lat_dreg  : lat_sreg;
        cur_base = base_mode_e'(cur_mode[1:0]);
        cur_ind  = cur_mode[2];
    end

    agu_regfile #(.DW(DW), .NREG(NREG), .RW(RW)) u_rf (
        .clk(clk), .rst_n(rst_n),
        .upd_we(upd_we), .upd_idx(upd_idx), .upd_data(upd_data),
        .ext_we(rf_we && !busy), .ext_idx(rf_waddr), .ext_data(rf_wdata),
        .ra_idx(rf_raddr), .ra_data(rf_rdata),
        .rb_idx(cur_reg),  .rb_data(cur_val),
        .rc_idx(IP_R),     .rc_data(ip_val)
    );

    agu_autostep #(.DW(DW), .RW(RW)) u_step (
        .val(cur_val), .ridx(cur_reg), .byte_op(lat_byte),
        .down(cur_base == AM_PREDEC), .res(step_val)
    );

    // Indexed address: base register (advanced pointer for the IP) plus displacement.
    assign idx_addr = ((cur_reg == IP_R) ? (ip_val + DW'(2)) : cur_val) + mem_rdata;

    // Odd instruction pointer needed by this operand.
    assign trap_now = ip_val[0] && (cur_mode != 3'd0) &&
                      ((cur_reg == IP_R) || (cur_base == AM_INDEX));

    // Per-state decisions: register update, operand finish, next fetch.
    always_comb begin
        upd_we = 1'b0; upd_idx = cur_reg; upd_data = step_val;
        fin = 1'b0; fin_is_reg = 1'b0; fin_ea = '0;
        go_ind = 1'b0; go_idx = 1'b0; nxt_ptr = '0;
        unique case (state)
            ST_EVAL: if (!trap_now) begin
                unique case (cur_base)
                    AM_REG: begin
                        fin        = 1'b1;
                        fin_is_reg = !cur_ind;
                        fin_ea     = cur_ind ? align_ea(cur_val, lat_byte)
                                             : {{(DW-RW){1'b0}}, cur_reg};
                    end
                    AM_PREDEC, AM_POSTINC: begin
                        upd_we  = 1'b1;
                        nxt_ptr = (cur_base == AM_PREDEC) ? step_val : cur_val;
                        go_ind  = cur_ind;
                        fin     = !cur_ind;
                        fin_ea  = align_ea(nxt_ptr, lat_byte);
                    end
                    AM_INDEX: go_idx = 1'b1;
                endcase
            end
            ST_IDX: if (mem_ready) begin
                upd_we   = 1'b1;
                upd_idx  = IP_R;
                upd_data = ip_val + DW'(2);
                nxt_ptr  = idx_addr;
                go_ind   = cur_ind;
                fin      = !cur_ind;
                fin_ea   = align_ea(idx_addr, lat_byte);
            end
            ST_IND: if (mem_ready) begin
                fin    = 1'b1;
                fin_ea = {mem_rdata[DW-1:1], 1'b0};
            end
            default: ;
        endcase
    end

    // Sequencer: accept, step through source then destination, report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE; phase_dst <= 1'b0; done <= 1'b0; align_trap <= 1'b0;
            lat_byte <= 1'b0; lat_smode <= '0; lat_dmode <= '0;
            lat_sreg <= '0; lat_dreg <= '0; ptr <= '0;
            src_is_reg <= 1'b0; src_ea <= '0; dst_is_reg <= 1'b0; dst_ea <= '0;
        end else begin
            done       <= 1'b0;
            align_trap <= 1'b0;
            if (state == ST_IDLE) begin
                if (start) begin
                    state <= ST_EVAL; phase_dst <= 1'b0; lat_byte <= is_byte;
                    lat_smode <= src_mode; lat_sreg <= src_reg;
                    lat_dmode <= dst_mode; lat_dreg <= dst_reg;
                end
            end else if (state == ST_EVAL && trap_now) begin
                state <= ST_IDLE; done <= 1'b1; align_trap <= 1'b1;
            end else if (fin) begin
                if (!phase_dst) begin
                    src_is_reg <= fin_is_reg; src_ea <= fin_ea;
                    phase_dst  <= 1'b1; state <= ST_EVAL;
                end else begin
                    dst_is_reg <= fin_is_reg; dst_ea <= fin_ea;
                    state <= ST_IDLE; done <= 1'b1;
                end
            end else if (go_ind) begin
                ptr <= nxt_ptr; state <= ST_IND;
            end else if (go_idx) begin
                state <= ST_IDX;
            end
        end
    end

    // Memory port: displacement fetch at the IP, pointer fetch at ptr.
    assign busy     = (state != ST_IDLE);
    assign mem_req  = (state == ST_IDX) || (state == ST_IND);
    assign mem_addr = (state == ST_IDX) ? ip_val : {ptr[DW-1:1], 1'b0};

    // R9: reads are word aligned.
    p_addr_even_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !mem_addr[0]);
    // R9: a pending read holds its address.
    p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)));
    // R10: completion is a single-cycle pulse.
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R10: a start while busy leaves the captured operation untouched.
    p_latch_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(lat_smode) && $stable(lat_dmode) && $stable(lat_sreg)));
    // R8: trap only accompanies completion.
    p_trap_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        align_trap |-> done);
    // R8: no displacement fetch through an odd instruction pointer.
    p_ip_even_idx_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDX) |-> !ip_val[0]);
endmodule

// File: tb/opnd_agu_tb_top.sv
// Directed bench for the operand address generation unit.
module opnd_agu_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, is_byte = 1'b0;
    logic [2:0]  src_mode = '0, src_reg = '0, dst_mode = '0, dst_reg = '0;
    logic        busy, done, align_trap, src_is_reg, dst_is_reg, mem_req, mem_ready;
    logic [15:0] src_ea, dst_ea, mem_addr, mem_rdata, rf_rdata;
    logic        rf_we = 1'b0;
    logic [2:0]  rf_waddr = '0, rf_raddr = '0;
    logic [15:0] rf_wdata = '0;

    int n_checks = 0, n_fail = 0;
    int mem_wait = 0, wcnt = 0, rd_cnt = 0, hs_err = 0;
    logic        prev_pend = 1'b0;
    logic [15:0] prev_addr = '0;

    always #5 clk = ~clk;

    opnd_agu dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .is_byte(is_byte),
        .src_mode(src_mode), .src_reg(src_reg), .dst_mode(dst_mode), .dst_reg(dst_reg),
        .busy(busy), .done(done), .align_trap(align_trap),
        .src_is_reg(src_is_reg), .src_ea(src_ea), .dst_is_reg(dst_is_reg), .dst_ea(dst_ea),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
        .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
        .rf_raddr(rf_raddr), .rf_rdata(rf_rdata)
    );

    // Memory model: word at a is a*3 + 0x0101.
    function automatic logic [15:0] memword(input logic [15:0] a);
        return a * 16'd3 + 16'h0101;
    endfunction
    assign mem_rdata = memword(mem_addr);
    assign mem_ready = mem_req && (wcnt == mem_wait);

    always @(posedge clk) begin
        if (mem_req && !mem_ready) wcnt <= wcnt + 1;
        else wcnt <= 0;
        if (mem_req && mem_ready) rd_cnt <= rd_cnt + 1;
    end

    // Handshake monitor for R9.
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_pend && (!mem_req || mem_addr != prev_addr)) hs_err++;
            if (mem_req && mem_addr[0]) hs_err++;
        end
        prev_pend = mem_req && !mem_ready;
        prev_addr = mem_addr;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        check(act == exp, req, what, act, exp);
    endtask

    task automatic set_reg(input logic [2:0] idx, input logic [15:0] v);
        @(negedge clk);
        rf_we = 1'b1; rf_waddr = idx; rf_wdata = v;
        @(negedge clk);
        rf_we = 1'b0;
    endtask

    task automatic get_reg(input logic [2:0] idx, output logic [15:0] v);
        rf_raddr = idx;
        #1;
        v = rf_rdata;
    endtask

    // Launch one operation, return falling edges from the start edge to done.
    task automatic run_op(input logic [2:0] sm, input logic [2:0] sr,
                          input logic [2:0] dm, input logic [2:0] dr,
                          input logic byt, output int lat);
        @(negedge clk);
        src_mode = sm; src_reg = sr; dst_mode = dm; dst_reg = dr; is_byte = byt;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 100) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic t_reset();
        logic [15:0] v;
        chk("R1", "busy", busy, 0);
        chk("R1", "done", done, 0);
        chk("R1", "trap", align_trap, 0);
        chk("R1", "mem_req", mem_req, 0);
        for (int i = 0; i < 8; i++) begin
            get_reg(3'(i), v);
            chk("R1", "reg after reset", v, 0);
        end
        set_reg(3'd4, 16'hBEEF);
        get_reg(3'd4, v);
        chk("R11", "port write/read", v, 16'hBEEF);
    endtask

    task automatic t_reg_direct();
        int lat, r0;
        r0 = rd_cnt;
        run_op(3'd0, 3'd3, 3'd0, 3'd5, 1'b0, lat);
        chk("R10", "latency reg direct", lat, 3);
        chk("R2", "src_is_reg", src_is_reg, 1);
        chk("R2", "src_ea reg num", src_ea, 3);
        chk("R2", "dst_is_reg", dst_is_reg, 1);
        chk("R2", "dst_ea reg num", dst_ea, 5);
        chk("R2", "no memory reads", rd_cnt - r0, 0);
    endtask

    task automatic t_deferred();
        int lat, r0;
        set_reg(3'd2, 16'h1235);
        r0 = rd_cnt;
        run_op(3'd4, 3'd2, 3'd4, 3'd2, 1'b0, lat);
        chk("R7", "word deferred aligned", src_ea, 16'h1234);
        chk("R2", "deferred not reg", src_is_reg, 0);
        chk("R2", "no memory reads deferred", rd_cnt - r0, 0);
        run_op(3'd4, 3'd2, 3'd0, 3'd1, 1'b1, lat);
        chk("R7", "byte deferred keeps bit0", src_ea, 16'h1235);
    endtask

    task automatic t_autoinc();
        int lat;
        logic [15:0] v;
        set_reg(3'd0, 16'h0100);
        run_op(3'd2, 3'd0, 3'd2, 3'd0, 1'b1, lat);
        chk("R6", "byte src postinc", src_ea, 16'h0100);
        chk("R6", "byte dst postinc next", dst_ea, 16'h0101);
        get_reg(3'd0, v);
        chk("R3", "byte postinc twice", v, 16'h0102);
        set_reg(3'd0, 16'h0200);
        run_op(3'd2, 3'd0, 3'd2, 3'd0, 1'b0, lat);
        chk("R6", "word src postinc", src_ea, 16'h0200);
        chk("R6", "word dst postinc next", dst_ea, 16'h0202);
        get_reg(3'd0, v);
        chk("R3", "word postinc twice", v, 16'h0204);
    endtask

    task automatic t_predec();
        int lat;
        logic [15:0] v;
        set_reg(3'd6, 16'h0400);
        set_reg(3'd1, 16'h0051);
        run_op(3'd1, 3'd6, 3'd1, 3'd1, 1'b1, lat);
        chk("R3", "sp predec byte steps 2", src_ea, 16'h03FE);
        get_reg(3'd6, v);
        chk("R3", "sp after predec", v, 16'h03FE);
        chk("R3", "r1 byte predec ea", dst_ea, 16'h0050);
        get_reg(3'd1, v);
        chk("R3", "r1 after predec", v, 16'h0050);
    endtask

    task automatic t_indexed(input int ws);
        int lat, r0;
        logic [15:0] v, d1, d2;
        mem_wait = ws;
        set_reg(3'd7, 16'h0020);
        set_reg(3'd4, 16'h1000);
        d1 = memword(16'h0020);
        d2 = memword(16'h0022);
        r0 = rd_cnt; hs_err = 0;
        run_op(3'd3, 3'd4, 3'd3, 3'd7, 1'b0, lat);
        chk("R10", "indexed latency", lat, 3 + 2 * (1 + ws));
        chk("R4", "src indexed ea", src_ea, (16'h1000 + d1) & 16'hFFFE);
        chk("R4", "dst indexed via IP ea", dst_ea, (16'h0024 + d2) & 16'hFFFE);
        get_reg(3'd7, v);
        chk("R4", "IP advanced", v, 16'h0024);
        chk("R4", "two reads", rd_cnt - r0, 2);
        chk("R9", "handshake errors", hs_err, 0);
        mem_wait = 0;
    endtask

    task automatic t_indirect();
        int lat;
        logic [15:0] v, p, d;
        mem_wait = 1;
        set_reg(3'd2, 16'h0040);
        set_reg(3'd7, 16'h0030);
        set_reg(3'd3, 16'h0010);
        hs_err = 0;
        run_op(3'd6, 3'd2, 3'd7, 3'd3, 1'b0, lat);
        chk("R10", "indirect latency", lat, 3 + 3 * 2);
        chk("R5", "src postinc deferred", src_ea, memword(16'h0040) & 16'hFFFE);
        get_reg(3'd2, v);
        chk("R5", "src reg stepped", v, 16'h0042);
        d = memword(16'h0030);
        p = (16'h0010 + d) & 16'hFFFE;
        chk("R5", "dst indexed deferred", dst_ea, memword(p) & 16'hFFFE);
        chk("R9", "handshake errors", hs_err, 0);
        mem_wait = 0;
        set_reg(3'd1, 16'h0081);
        run_op(3'd5, 3'd1, 3'd0, 3'd0, 1'b1, lat);
        chk("R5", "byte predec deferred", src_ea, memword(16'h0080) & 16'hFFFE);
    endtask

    task automatic t_trap();
        int lat, r0;
        logic [15:0] v;
        set_reg(3'd7, 16'h0031);
        r0 = rd_cnt;
        run_op(3'd3, 3'd1, 3'd0, 3'd0, 1'b0, lat);
        chk("R8", "trap latency src", lat, 2);
        chk("R8", "trap flag", align_trap, 1);
        chk("R8", "no read on trap", rd_cnt - r0, 0);
        get_reg(3'd7, v);
        chk("R8", "IP unchanged", v, 16'h0031);
        run_op(3'd0, 3'd2, 3'd2, 3'd7, 1'b0, lat);
        chk("R8", "trap latency dst", lat, 3);
        chk("R8", "trap flag dst", align_trap, 1);
        get_reg(3'd7, v);
        chk("R8", "IP unchanged dst", v, 16'h0031);
        run_op(3'd0, 3'd2, 3'd0, 3'd7, 1'b0, lat);
        chk("R8", "reg direct IP no trap", align_trap, 0);
        set_reg(3'd7, 16'h0000);
    endtask

    task automatic t_busy_ignore();
        int lat;
        logic [15:0] v;
        mem_wait = 2;
        set_reg(3'd7, 16'h0010);
        set_reg(3'd5, 16'h0aaa);
        @(negedge clk);
        src_mode = 3'd3; src_reg = 3'd5; dst_mode = 3'd0; dst_reg = 3'd1; is_byte = 1'b0;
        start = 1'b1;
        @(negedge clk);
        src_mode = 3'd0; src_reg = 3'd6; dst_mode = 3'd0; dst_reg = 3'd6;
        rf_we = 1'b1; rf_waddr = 3'd5; rf_wdata = 16'h5555;
        lat = 1;
        @(negedge clk);
        start = 1'b0; rf_we = 1'b0;
        lat = 2;
        while (!done && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        chk("R10", "latency with start while busy", lat, 3 + 3);
        chk("R10", "dst from first op", dst_ea, 1);
        chk("R10", "src from first op", src_ea, (16'h0aaa + memword(16'h0010)) & 16'hFFFE);
        get_reg(3'd5, v);
        chk("R11", "write ignored while busy", v, 16'h0aaa);
        mem_wait = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_reg_direct();
        t_deferred();
        t_autoinc();
        t_predec();
        t_indexed(0);
        t_indexed(2);
        t_indirect();
        t_trap();
        t_busy_ignore();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule